// File: doc/BRIEF.md
# Floating-Point Exception Cause and Trap Controller

This block sits beside a floating-point arithmetic datapath. It holds the control/status word for five exception kinds: invalid operation (V), divide by zero (Z), overflow (O), underflow (U) and inexact (I). For each kind there is an enable bit and a cause bit. A start strobe clears the cause bits. A done strobe comes with the datapath's raw status flags and its direct invalid and divide-by-zero indications. From these the block picks the one cause to record and decides whether the result may be committed. When no cause is recorded for an invalid operation, it selects the default quiet NaN as the result.

In the cycle after the done strobe, a one-cycle trap request goes out with an exception code. The code is 0x1d0 for an arithmetic cause, 0x1c0 for an operation issued while the unit is switched off, and 0x1c8 for an unimplemented instruction. Software can write only the enable bits. The cause bits are read-only.

Top module: `fpx_trap_ctl`

## Requirements
- R1: After reset, csr_o is 0, trap_o is 0 and trap_code_o is 0. While no operation is done, wb_o and qnan_o are 0.
- R2: A write with cfg_we_i loads cfg_wdata_i[4:0] into the enables, in the bit order V=4, Z=3, O=2, U=1, I=0. The other write bits are ignored, and the cause bits csr_o[12:8] (same order) keep their value.
- R3: op_start_i without op_done_i clears all cause bits at the next clock edge.
- R4: If inv_i is set and the V enable is set, only the V cause is recorded and wb_o stays 0. If the V enable is clear, no cause is recorded and wb_o and qnan_o are both 1.
- R5: If dz_i is set and the Z enable is set, only the Z cause is recorded and wb_o is 0. If the Z enable is clear, the result is committed with no cause recorded.
- R6: Overflow status with the O enable set records only the O cause and blocks write-back.
- R7: The recorded cause follows a fixed priority: invalid, then divide by zero, then overflow, then underflow or denormal, then inexact or rounded. A status whose enable is clear falls through to the next step. At most one cause is recorded per operation.
- R8: A status present with its enable clear sets no cause. wb_o is 1 during the done cycle.
- R9: trap_o is high for exactly the one cycle after op_done_i. It is high exactly when a cause was recorded (code 0x1d0) or a special case of R10 applies. trap_code_o is 0 whenever trap_o is 0.
- R10: fpu_off_i with op_done_i gives trap code 0x1c0. unimp_i gives 0x1c8, and fpu_off_i wins when both are set. In both cases no cause is recorded and wb_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Enable-bit write strobe |
| cfg_wdata_i | input | 16 | Write data; bits [4:0] are the enables |
| op_start_i | input | 1 | Operation start; clears causes |
| op_done_i | input | 1 | Operation done; flags below are valid |
| st_ovf_i | input | 1 | Overflow status |
| st_unf_i | input | 1 | Underflow status |
| st_den_i | input | 1 | Denormal result status |
| st_inx_i | input | 1 | Inexact status |
| st_rnd_i | input | 1 | Rounded status |
| inv_i | input | 1 | Invalid operation detected |
| dz_i | input | 1 | Finite operand divided by zero |
| fpu_off_i | input | 1 | Unit disabled when instruction issued |
| unimp_i | input | 1 | Unimplemented instruction |
| csr_o | output | 16 | Enables [4:0], causes [12:8] |
| wb_o | output | 1 | Result may be written back (done cycle) |
| qnan_o | output | 1 | Write default quiet NaN as result |
| trap_o | output | 1 | Trap request pulse |
| trap_code_o | output | 9 | Exception code with trap_o |

## Verification
Several properties are checked on every cycle:
- At most one of the overflow, underflow and inexact causes is held.
- Cause bits change only on a start or done strobe, and a lone start leaves them at zero.
- Write-back, NaN select and trap appear only in their own cycles relative to the done strobe.
- A trap always carries a nonzero code.

The bench scenarios show what these properties cannot: the fall-through of disabled statuses, which cause wins among several flags, the quiet-NaN path, the enable write mask, and the exact code value for each special case.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int NUM_CAUSES = 5;
  localparam int CODE_W     = 9;

  // bit positions inside the enable and cause fields
  localparam int CI_INX = 0;
  localparam int CI_UNF = 1;
  localparam int CI_OVF = 2;
  localparam int CI_DZ  = 3;
  localparam int CI_INV = 4;

  localparam logic [CODE_W-1:0] CODE_OFF   = 9'h1c0;
  localparam logic [CODE_W-1:0] CODE_UNIMP = 9'h1c8;
  localparam logic [CODE_W-1:0] CODE_ARITH = 9'h1d0;

  typedef struct packed {
    logic ovf;
    logic unf;
    logic den;
    logic inx;
    logic rnd;
  } rstat_t;
endpackage

// File: rtl/fpx_cause_eval.sv
module fpx_cause_eval
  import fpx_pkg::*;
(
  input  rstat_t                  stat_i,
  input  logic                    inv_i,
  input  logic                    dz_i,
  input  logic                    off_i,
  input  logic                    unimp_i,
  input  logic [NUM_CAUSES-1:0]   en_i,
  output logic [NUM_CAUSES-1:0]   cause_o,
  output logic                    commit_o,
  output logic                    qnan_o,
  output logic                    trap_o,
  output logic [CODE_W-1:0]       code_o
);
  always_comb begin
    cause_o  = '0;
    commit_o = 1'b1;
    qnan_o   = 1'b0;
    code_o   = CODE_ARITH;
    if (off_i) begin
      commit_o = 1'b0;
      code_o   = CODE_OFF;
    end else if (unimp_i) begin
      commit_o = 1'b0;
      code_o   = CODE_UNIMP;
    end else if (inv_i) begin
      if (en_i[CI_INV]) begin
        cause_o[CI_INV] = 1'b1;
        commit_o        = 1'b0;
      end else begin
        qnan_o = 1'b1;
      end
    end else if (dz_i && en_i[CI_DZ]) begin
      cause_o[CI_DZ] = 1'b1;
      commit_o       = 1'b0;
    end else if (stat_i.ovf && en_i[CI_OVF]) begin
      cause_o[CI_OVF] = 1'b1;
      commit_o        = 1'b0;
    end else if ((stat_i.unf || stat_i.den) && en_i[CI_UNF]) begin
      cause_o[CI_UNF] = 1'b1;
      commit_o        = 1'b0;
    end else if ((stat_i.inx || stat_i.rnd) && en_i[CI_INX]) begin
      cause_o[CI_INX] = 1'b1;
      commit_o        = 1'b0;
    end
    trap_o = off_i || unimp_i || (|cause_o);
  end
endmodule

// File: rtl/fpx_csr.sv
module fpx_csr
  import fpx_pkg::*;
#(
  parameter int CSR_W     = 16,
  parameter int CAUSE_LSB = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_we_i,
  input  logic [CSR_W-1:0]      cfg_wdata_i,
  input  logic                  op_start_i,
  input  logic                  op_done_i,
  input  logic [NUM_CAUSES-1:0] cause_new_i,
  output logic [NUM_CAUSES-1:0] en_o,
  output logic [NUM_CAUSES-1:0] cause_o,
  output logic [CSR_W-1:0]      csr_o
);
  logic [NUM_CAUSES-1:0] en_q, cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (cfg_we_i) begin
      en_q <= cfg_wdata_i[NUM_CAUSES-1:0];
    end
  end

  // done wins over start when both arrive together
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
    end else if (op_done_i) begin
      cause_q <= cause_new_i;
    end else if (op_start_i) begin
      cause_q <= '0;
    end
  end

  always_comb begin
    csr_o = '0;
    csr_o[NUM_CAUSES-1:0]           = en_q;
    csr_o[CAUSE_LSB +: NUM_CAUSES]  = cause_q;
  end

  assign en_o    = en_q;
  assign cause_o = cause_q;

  assert_one_result_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cause_q[CI_OVF:CI_INX]));

  assert_start_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_start_i && !op_done_i) |=> (cause_q == '0));

  assert_cause_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_start_i && !op_done_i) |=> $stable(cause_q));
endmodule

// File: rtl/fpx_trap_ctl.sv
module fpx_trap_ctl
  import fpx_pkg::*;
#(
  parameter int CSR_W     = 16,
  parameter int CAUSE_LSB = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CSR_W-1:0]  cfg_wdata_i,
  input  logic              op_start_i,
  input  logic              op_done_i,
  input  logic              st_ovf_i,
  input  logic              st_unf_i,
  input  logic              st_den_i,
  input  logic              st_inx_i,
  input  logic              st_rnd_i,
  input  logic              inv_i,
  input  logic              dz_i,
  input  logic              fpu_off_i,
  input  logic              unimp_i,
  output logic [CSR_W-1:0]  csr_o,
  output logic              wb_o,
  output logic              qnan_o,
  output logic              trap_o,
  output logic [CODE_W-1:0] trap_code_o
);
  localparam int CAUSE_MSB = CAUSE_LSB + NUM_CAUSES - 1;

  rstat_t                stat;
  logic [NUM_CAUSES-1:0] en, cause_q, cause_new;
  logic                  commit, qnan_sel, trap_new;
  logic [CODE_W-1:0]     code_new;
  logic                  trap_q;
  logic [CODE_W-1:0]     code_q;

  assign stat = '{ovf: st_ovf_i, unf: st_unf_i, den: st_den_i,
                  inx: st_inx_i, rnd: st_rnd_i};

  fpx_cause_eval u_eval (
    .stat_i   (stat),
    .inv_i    (inv_i),
    .dz_i     (dz_i),
    .off_i    (fpu_off_i),
    .unimp_i  (unimp_i),
    .en_i     (en),
    .cause_o  (cause_new),
    .commit_o (commit),
    .qnan_o   (qnan_sel),
    .trap_o   (trap_new),
    .code_o   (code_new)
  );

  fpx_csr #(.CSR_W(CSR_W), .CAUSE_LSB(CAUSE_LSB)) u_csr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (cfg_wdata_i),
    .op_start_i  (op_start_i),
    .op_done_i   (op_done_i),
    .cause_new_i (cause_new),
    .en_o        (en),
    .cause_o     (cause_q),
    .csr_o       (csr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_q <= 1'b0;
      code_q <= '0;
    end else begin
      trap_q <= op_done_i && trap_new;
      code_q <= (op_done_i && trap_new) ? code_new : '0;
    end
  end

  assign wb_o        = op_done_i && commit;
  assign qnan_o      = op_done_i && qnan_sel;
  assign trap_o      = trap_q;
  assign trap_code_o = code_q;

  initial assert (CAUSE_MSB < CSR_W);

  assert_wb_in_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_o || qnan_o) |-> op_done_i);

  assert_trap_after_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $past(op_done_i));

  assert_code_with_trap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o == (trap_code_o != '0));

  assert_cause_traps_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_done_i && !fpu_off_i && !unimp_i) |=> (trap_o == (csr_o[CAUSE_MSB:CAUSE_LSB] != '0)));

  assert_special_no_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_done_i && (fpu_off_i || unimp_i)) |=> (trap_o && csr_o[CAUSE_MSB:CAUSE_LSB] == '0));
endmodule

// File: tb/fpx_trap_ctl_test.sv
module fpx_trap_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        op_start = 1'b0, op_done = 1'b0;
  logic        st_ovf = 1'b0, st_unf = 1'b0, st_den = 1'b0, st_inx = 1'b0, st_rnd = 1'b0;
  logic        inv = 1'b0, dz = 1'b0, fpu_off = 1'b0, unimp = 1'b0;
  logic [15:0] csr;
  logic        wb, qnan, trap;
  logic [8:0]  trap_code;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fpx_trap_ctl uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .op_start_i(op_start), .op_done_i(op_done),
    .st_ovf_i(st_ovf), .st_unf_i(st_unf), .st_den_i(st_den),
    .st_inx_i(st_inx), .st_rnd_i(st_rnd), .inv_i(inv), .dz_i(dz),
    .fpu_off_i(fpu_off), .unimp_i(unimp), .csr_o(csr), .wb_o(wb),
    .qnan_o(qnan), .trap_o(trap), .trap_code_o(trap_code)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_en(input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  // st = {ovf,unf,den,inx,rnd}; exp_cause in V,Z,O,U,I order (bit4..0); exp_code 0 = no trap
  task automatic do_op(input string tag, input logic [4:0] st, input logic i_inv,
                       input logic i_dz, input logic i_off, input logic i_unimp,
                       input logic [4:0] exp_cause, input logic exp_wb,
                       input logic exp_qnan, input logic [8:0] exp_code);
    @(negedge clk);
    op_start = 1'b1;
    @(negedge clk);
    op_start = 1'b0;
    {st_ovf, st_unf, st_den, st_inx, st_rnd} = st;
    inv = i_inv; dz = i_dz; fpu_off = i_off; unimp = i_unimp;
    op_done = 1'b1;
    #1;
    chk({tag, " wb"}, 32'(wb), 32'(exp_wb));
    chk({tag, " qnan"}, 32'(qnan), 32'(exp_qnan));
    chk({tag, " no early trap"}, 32'(trap), 32'd0);
    @(negedge clk);
    chk({tag, " cause"}, 32'(csr[12:8]), 32'(exp_cause));
    chk({tag, " trap"}, 32'(trap), 32'(exp_code != 9'd0));
    chk({tag, " code"}, 32'(trap_code), 32'(exp_code));
    op_done = 1'b0;
    {st_ovf, st_unf, st_den, st_inx, st_rnd} = '0;
    inv = 1'b0; dz = 1'b0; fpu_off = 1'b0; unimp = 1'b0;
    @(negedge clk);
    chk({tag, " trap single pulse"}, 32'(trap), 32'd0);
    chk({tag, " cause held"}, 32'(csr[12:8]), 32'(exp_cause));
  endtask

  task automatic t_reset;
    chk("R1 csr", 32'(csr), 32'h0);
    chk("R1 trap", 32'(trap), 32'd0);
    chk("R1 code", 32'(trap_code), 32'd0);
    chk("R1 wb", 32'(wb), 32'd0);
    chk("R1 qnan", 32'(qnan), 32'd0);
  endtask

  task automatic t_enable_write;
    wr_en(16'hFFE0);
    chk("R2 upper bits ignored", 32'(csr), 32'h0);
    wr_en(16'hFFFF);
    chk("R2 all enables", 32'(csr), 32'h001F);
  endtask

  task automatic t_overflow;
    wr_en(16'h001F);
    do_op("R6 ovf", 5'b10000, 0, 0, 0, 0, 5'b00100, 0, 0, 9'h1d0);
    do_op("R7 ovf+unf+inx", 5'b11010, 0, 0, 0, 0, 5'b00100, 0, 0, 9'h1d0);
  endtask

  task automatic t_priority;
    wr_en(16'h001B);  // O disabled
    do_op("R7 ovf off falls to U", 5'b11000, 0, 0, 0, 0, 5'b00010, 0, 0, 9'h1d0);
    wr_en(16'h0002);
    do_op("R7 den gives U", 5'b00100, 0, 0, 0, 0, 5'b00010, 0, 0, 9'h1d0);
    wr_en(16'h0001);
    do_op("R7 rnd gives I", 5'b00001, 0, 0, 0, 0, 5'b00001, 0, 0, 9'h1d0);
    wr_en(16'h001F);
    do_op("R7 inv beats dz and ovf", 5'b10000, 1, 1, 0, 0, 5'b10000, 0, 0, 9'h1d0);
    do_op("R7 dz beats ovf", 5'b10000, 0, 1, 0, 0, 5'b01000, 0, 0, 9'h1d0);
  endtask

  task automatic t_disabled_status;
    wr_en(16'h0018);
    do_op("R8 disabled statuses commit", 5'b11111, 0, 0, 0, 0, 5'b00000, 1, 0, 9'h0);
  endtask

  task automatic t_invalid;
    wr_en(16'h0010);
    do_op("R4 inv enabled", 5'b00000, 1, 0, 0, 0, 5'b10000, 0, 0, 9'h1d0);
    wr_en(16'h000F);
    do_op("R4 inv disabled qnan", 5'b00000, 1, 0, 0, 0, 5'b00000, 1, 1, 9'h0);
  endtask

  task automatic t_divzero;
    wr_en(16'h0008);
    do_op("R5 dz enabled", 5'b00000, 0, 1, 0, 0, 5'b01000, 0, 0, 9'h1d0);
    wr_en(16'h0017);
    do_op("R5 dz disabled commits", 5'b00000, 0, 1, 0, 0, 5'b00000, 1, 0, 9'h0);
  endtask

  task automatic t_start_clear;
    wr_en(16'h001F);
    do_op("R3 setup", 5'b10000, 0, 0, 0, 0, 5'b00100, 0, 0, 9'h1d0);
    wr_en(16'h0003);
    chk("R2 write keeps causes", 32'(csr), 32'h0403);
    @(negedge clk);
    op_start = 1'b1;
    @(negedge clk);
    op_start = 1'b0;
    chk("R3 start clears causes", 32'(csr[12:8]), 32'd0);
    chk("R3 no trap on start", 32'(trap), 32'd0);
  endtask

  task automatic t_special;
    wr_en(16'h001F);
    do_op("R10 unit off", 5'b10000, 1, 0, 1, 0, 5'b00000, 0, 0, 9'h1c0);
    do_op("R10 unimplemented", 5'b00010, 0, 1, 0, 1, 5'b00000, 0, 0, 9'h1c8);
    do_op("R10 off wins", 5'b00000, 0, 0, 1, 1, 5'b00000, 0, 0, 9'h1c0);
  endtask

  task automatic t_clean;
    wr_en(16'h001F);
    do_op("R9 clean op no trap", 5'b00000, 0, 0, 0, 0, 5'b00000, 1, 0, 9'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_write();
    t_overflow();
    t_priority();
    t_disabled_status();
    t_invalid();
    t_divzero();
    t_start_clear();
    t_special();
    t_clean();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule